// File: doc/BRIEF.md
# Kernel Queue Dispatch Unit

This block sits between the command front end of a many-core compute device and its thread-block scheduler. Kernel launch descriptors arrive on a set of independent hardware work queues. Each descriptor carries an entry program counter, a count of thread blocks, grid and block dimensions and the address of the argument area. The block keeps the queues in order and moves kernels from the queue heads into a small distributor table. From that table it hands descriptors to the block scheduler in the order they were admitted.

A queue is serialized against itself. Once a kernel from a queue is admitted to the table, that queue's next kernel waits until a completion arrives for the table slot of the running kernel. Kernels from different queues can be in flight together. The table has one slot per queue, so the number of kernels in flight never exceeds the number of queues. When several queue heads are eligible in the same cycle, a round-robin arbiter admits one of them.

Top module: `kqd_top`

## Requirements
- R1: After reset, `sched_valid` is 0 and every bit of `push_ready` is 1.
- R2: A queue takes a push only while its `push_ready` bit is 1. The bit drops once the queue holds QDEPTH descriptors that have not been admitted. A push offered while the bit is 0 is dropped and never reaches `sched_desc`.
- R3: The kernels from one queue reach the scheduler in the order they were pushed.
- R4: After a kernel from queue q is admitted, no further kernel from q is presented until `done_valid` is pulsed with that kernel's slot index.
- R5: Kernels from different queues are all presented without any completion in between. Up to NQ kernels can be in flight at once.
- R6: Among queue heads that are eligible together, admission follows round-robin order. It starts at queue 0 after reset, and after each admission it resumes at the queue just after the winner.
- R7: At most one kernel is admitted into the table per cycle.
- R8: While `sched_valid` is 1 and `sched_ready` is 0, `sched_desc` and `sched_slot` hold their values.
- R9: An admitted kernel takes the lowest-numbered free table slot and reports it on `sched_slot`. A completion on that slot frees it for reuse.
- R10: Descriptors are presented to the scheduler in admission order. A descriptor is `{entry_pc[31:0], blocks_left[15:0], grid_dim[15:0], tb_dim[15:0], arg_addr[31:0]}` with the MSB first, 112 bits in all, and it is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | NQ | Per-queue push strobe |
| push_desc | input | NQ*112 | Per-queue descriptor; queue q uses bits [q*112 +: 112] |
| push_ready | output | NQ | Queue q has room for a push |
| sched_valid | output | 1 | A descriptor is offered to the block scheduler |
| sched_ready | input | 1 | Block scheduler accepts the offered descriptor |
| sched_desc | output | 112 | Offered descriptor |
| sched_slot | output | log2(NQ) | Table slot of the offered descriptor |
| done_valid | input | 1 | Completion strobe for a table slot |
| done_slot | input | log2(NQ) | Slot whose kernel has completed |

## Verification
The assertions assume that `done_valid` only ever names a slot that is occupied, which means its descriptor has already been handed to the scheduler and has not yet been completed. They also assume that each slot is completed only once. The stimulus keeps to this by taking every slot number for a completion from a descriptor it has already received on `sched_slot`, and by sending one completion per received descriptor. Pushes are offered with no regard to `push_ready`, because dropping a push to a full queue is part of the checked behaviour.

// File: rtl/kqd_pkg.sv
// Shared types of the kernel queue dispatch unit.
// Assumes: field widths are fixed for the whole device.
package kqd_pkg;
    localparam int PC_W   = 32;
    localparam int CNT_W  = 16;
    localparam int DIM_W  = 16;
    localparam int ADDR_W = 32;

    typedef struct packed {
        logic [PC_W-1:0]   entry_pc;
        logic [CNT_W-1:0]  blocks_left;
        logic [DIM_W-1:0]  grid_dim;
        logic [DIM_W-1:0]  tb_dim;
        logic [ADDR_W-1:0] arg_addr;
    } kdesc_t;

    localparam int DESC_W = $bits(kdesc_t);
endpackage

// File: rtl/kqd_fifo.sv
// Synchronous FIFO with a fall-through head (rd_data is valid while !empty).
// Assumes: DEPTH >= 2; the caller never writes when full or reads when empty.
module kqd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign rd_data = mem[rd_ptr];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (wr_en && !rd_en)      count <= count + 1'b1;
            else if (rd_en && !wr_en) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/kqd_rr_arb.sv
// Round-robin arbiter: grants the first request at or after the pointer.
// Assumes: the pointer moves past the winner only when take is high.
module kqd_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 take,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] grant_idx,
    output logic                 any
);
    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0] ptr;

    // Rotating priority search starting at ptr.
    always_comb begin
        int c;
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int i = 0; i < N; i++) begin
            c = (int'(ptr) + i) % N;
            if (!any && req[c]) begin
                any       = 1'b1;
                grant[c]  = 1'b1;
                grant_idx = IDX_W'(c);
            end
        end
    end

    // Advance priority past the winner on a taken grant.
    always_ff @(posedge clk) begin
        if (!rst_n)           ptr <= '0;
        else if (take && any) ptr <= (grant_idx == IDX_W'(N-1)) ? '0 : grant_idx + 1'b1;
    end
endmodule

// File: rtl/kqd_slot_table.sv
// Kernel distributor table: N slots, lowest-free allocation, FIFO of
// admitted slot indices toward the scheduler, release on completion.
// Assumes: completions name only occupied slots.
module kqd_slot_table
    import kqd_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_en,
    input  logic [DESC_W-1:0]    alloc_desc,
    input  logic [$clog2(N)-1:0] alloc_owner,
    output logic                 free_avail,
    output logic                 out_valid,
    output logic [DESC_W-1:0]    out_desc,
    output logic [$clog2(N)-1:0] out_slot,
    input  logic                 out_ready,
    input  logic                 done_valid,
    input  logic [$clog2(N)-1:0] done_slot,
    output logic                 rel_en,
    output logic [$clog2(N)-1:0] rel_owner,
    output logic [N-1:0]         alloc_mask
);
    localparam int SLOT_W = $clog2(N);

    kdesc_t            entry [N];
    logic [SLOT_W-1:0] owner [N];
    logic [SLOT_W-1:0] free_slot;
    logic              any_free;
    logic              ord_full, ord_empty;

    // Lowest-numbered free slot.
    always_comb begin
        free_slot = '0;
        any_free  = 1'b0;
        for (int i = N-1; i >= 0; i--) begin
            if (!alloc_mask[i]) begin
                free_slot = SLOT_W'(i);
                any_free  = 1'b1;
            end
        end
    end

    assign free_avail = any_free && !ord_full;
    assign rel_en     = done_valid && alloc_mask[done_slot];
    assign rel_owner  = owner[done_slot];
    assign out_valid  = !ord_empty;
    assign out_desc   = entry[out_slot];

    // Slot contents written on admission.
    always_ff @(posedge clk) begin
        if (alloc_en) begin
            entry[free_slot] <= kdesc_t'(alloc_desc);
            owner[free_slot] <= alloc_owner;
        end
    end

    // Occupancy: set on admission, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_mask <= '0;
        end else begin
            if (alloc_en) alloc_mask[free_slot] <= 1'b1;
            if (rel_en)   alloc_mask[done_slot] <= 1'b0;
        end
    end

    kqd_fifo #(.W(SLOT_W), .DEPTH(N)) u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (alloc_en),
        .wr_data (free_slot),
        .full    (ord_full),
        .rd_en   (out_valid && out_ready),
        .rd_data (out_slot),
        .empty   (ord_empty)
    );
endmodule

// File: rtl/kqd_top.sv
// Kernel queue dispatch unit: NQ work queues, one kernel in flight per
// queue, round-robin admission of one kernel per cycle into the table.
// Assumes: NQ >= 2, QDEPTH >= 2; completions name occupied slots.
module kqd_top
    import kqd_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int QDEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NQ-1:0]            push_valid,
    input  logic [NQ*DESC_W-1:0]     push_desc,
    output logic [NQ-1:0]            push_ready,
    output logic                     sched_valid,
    input  logic                     sched_ready,
    output logic [DESC_W-1:0]        sched_desc,
    output logic [$clog2(NQ)-1:0]    sched_slot,
    input  logic                     done_valid,
    input  logic [$clog2(NQ)-1:0]    done_slot
);
    localparam int QI_W = $clog2(NQ);

    logic [DESC_W-1:0] head [NQ];
    logic [NQ-1:0]     q_full, q_empty, eligible, grant, pop_q, busy_q, alloc_mask;
    logic [QI_W-1:0]   grant_idx, rel_owner;
    logic              any_req, free_avail, admit, rel_en;

    // One FIFO per hardware queue.
    for (genvar q = 0; q < NQ; q++) begin : g_queue
        kqd_fifo #(.W(DESC_W), .DEPTH(QDEPTH)) u_q (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (push_valid[q] && !q_full[q]),
            .wr_data (push_desc[q*DESC_W +: DESC_W]),
            .full    (q_full[q]),
            .rd_en   (pop_q[q]),
            .rd_data (head[q]),
            .empty   (q_empty[q])
        );
    end

    assign push_ready = ~q_full;
    assign eligible   = ~q_empty & ~busy_q;
    assign admit      = any_req && free_avail;
    assign pop_q      = grant & {NQ{admit}};

    kqd_rr_arb #(.N(NQ)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (eligible),
        .take      (admit),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any       (any_req)
    );

    kqd_slot_table #(.N(NQ)) u_tab (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en    (admit),
        .alloc_desc  (head[grant_idx]),
        .alloc_owner (grant_idx),
        .free_avail  (free_avail),
        .out_valid   (sched_valid),
        .out_desc    (sched_desc),
        .out_slot    (sched_slot),
        .out_ready   (sched_ready),
        .done_valid  (done_valid),
        .done_slot   (done_slot),
        .rel_en      (rel_en),
        .rel_owner   (rel_owner),
        .alloc_mask  (alloc_mask)
    );

    // Per-queue in-flight flag: set on admission, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            for (int q = 0; q < NQ; q++) begin
                if (pop_q[q])                                  busy_q[q] <= 1'b1;
                else if (rel_en && rel_owner == QI_W'(q))      busy_q[q] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/kqd_chk.sv
// Property checker for kqd_top, attached by bind.
// Assumes: same parameters as the bound instance.
module kqd_chk #(
    parameter int NQ     = 4,
    parameter int DESC_W = 112
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NQ-1:0]         push_ready,
    input logic                  sched_valid,
    input logic                  sched_ready,
    input logic [DESC_W-1:0]     sched_desc,
    input logic [$clog2(NQ)-1:0] sched_slot,
    input logic                  done_valid,
    input logic [$clog2(NQ)-1:0] done_slot,
    input logic [NQ-1:0]         busy,
    input logic [NQ-1:0]         pop,
    input logic [NQ-1:0]         alloc,
    input logic                  rel_en,
    input logic [$clog2(NQ)-1:0] rel_owner
);
    localparam int QI_W = $clog2(NQ);

    // R7
    one_admit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pop));

    // R8
    sched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sched_valid && !sched_ready |=> sched_valid && $stable(sched_desc) && $stable(sched_slot));

    // R9
    slot_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sched_valid |-> alloc[sched_slot]);

    // R9
    done_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> alloc[done_slot]);

    for (genvar q = 0; q < NQ; q++) begin : g_q
        // R2
        full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !push_ready[q] && !pop[q] |=> !push_ready[q]);

        // R4
        admit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pop[q] |=> busy[q]);

        // R4
        busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            busy[q] && !(rel_en && rel_owner == QI_W'(q)) |=> busy[q]);
    end
endmodule

bind kqd_top kqd_chk #(.NQ(NQ), .DESC_W(kqd_pkg::DESC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_ready  (push_ready),
    .sched_valid (sched_valid),
    .sched_ready (sched_ready),
    .sched_desc  (sched_desc),
    .sched_slot  (sched_slot),
    .done_valid  (done_valid),
    .done_slot   (done_slot),
    .busy        (busy_q),
    .pop         (pop_q),
    .alloc       (alloc_mask),
    .rel_en      (rel_en),
    .rel_owner   (rel_owner)
);

// File: tb/tb_kqd_top.sv
module tb_kqd_top;
    import kqd_pkg::*;

    localparam int NQ = 4;
    localparam int QD = 4;
    localparam int SW = $clog2(NQ);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NQ-1:0]        push_valid = '0;
    logic [NQ*DESC_W-1:0] push_desc = '0;
    logic [NQ-1:0]        push_ready;
    logic                 sched_valid;
    logic                 sched_ready = 1'b0;
    logic [DESC_W-1:0]    sched_desc;
    logic [SW-1:0]        sched_slot;
    logic                 done_valid = 1'b0;
    logic [SW-1:0]        done_slot = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    kqd_top #(.NQ(NQ), .QDEPTH(QD)) dut (.*);

    function automatic logic [DESC_W-1:0] mk(int q, int s);
        kdesc_t d;
        d.entry_pc    = 32'h1000_0000 + 32'(q * 256 + s);
        d.blocks_left = 16'(s + 1);
        d.grid_dim    = 16'(q + 2);
        d.tb_dim      = 16'd64;
        d.arg_addr    = 32'hA000_0000 + 32'(q * 4096 + s * 16);
        return d;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push1(input int q, input logic [DESC_W-1:0] d, output bit acc);
        acc = push_ready[q];
        push_valid[q] = 1'b1;
        push_desc[q*DESC_W +: DESC_W] = d;
        @(negedge clk);
        push_valid[q] = 1'b0;
    endtask

    task automatic take(output logic [DESC_W-1:0] d, output logic [SW-1:0] s);
        while (!sched_valid) @(negedge clk);
        d = sched_desc;
        s = sched_slot;
        sched_ready = 1'b1;
        @(negedge clk);
        sched_ready = 1'b0;
    endtask

    task automatic done1(input logic [SW-1:0] s);
        done_valid = 1'b1;
        done_slot  = s;
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [DESC_W-1:0] d, held;
        logic [SW-1:0]     s, hs;
        bit                acc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(sched_valid == 1'b0, "R1 sched_valid", 128'(sched_valid), 0);
        chk(push_ready == '1, "R1 push_ready", 128'(push_ready), 128'({NQ{1'b1}}));

        // Per queue: overfill, then drain one kernel at a time
        for (int q = 0; q < NQ; q++) begin
            for (int i = 0; i < QD + 1; i++) begin
                push1(q, mk(q, i), acc);
                chk(acc, "R2 push accepted", 128'(acc), 1);
            end
            // R2: queue full after QDEPTH pending plus one admitted
            chk(push_ready[q] == 1'b0, "R2 ready low when full", 128'(push_ready[q]), 0);
            push1(q, mk(q, 99), acc);
            chk(!acc, "R2 push refused", 128'(acc), 0);
            for (int i = 0; i < QD + 1; i++) begin
                take(d, s);
                // R3, R10: in push order, unchanged
                chk(d == mk(q, i), "R3 queue order", 128'(d), 128'(mk(q, i)));
                // R9: lowest free slot
                chk(s == '0, "R9 slot zero", 128'(s), 0);
                repeat (3) @(negedge clk);
                // R4: next kernel of the same queue waits for completion
                chk(!sched_valid, "R4 serialized", 128'(sched_valid), 0);
                done1(s);
            end
            repeat (4) @(negedge clk);
            // R2: refused push never appears
            chk(!sched_valid, "R2 dropped push absent", 128'(sched_valid), 0);
            chk(push_ready == '1, "R2 ready restored", 128'(push_ready), 128'({NQ{1'b1}}));
        end

        // All queues at once: pointer is back at queue 0
        for (int q = 0; q < NQ; q++) push_desc[q*DESC_W +: DESC_W] = mk(q, 8);
        push_valid = '1;
        @(negedge clk);
        push_valid = '0;
        repeat (6) @(negedge clk);
        held = sched_desc;
        hs   = sched_slot;
        chk(sched_valid, "R8 valid while stalled", 128'(sched_valid), 1);
        repeat (3) @(negedge clk);
        // R8: output held while not accepted
        chk(sched_valid && sched_desc == held && sched_slot == hs, "R8 stable", 128'(sched_desc), 128'(held));
        for (int k = 0; k < NQ; k++) begin
            take(d, s);
            // R5, R6, R10: all queues in flight, round-robin from queue 0
            chk(d == mk(k, 8), "R6 rr order", 128'(d), 128'(mk(k, 8)));
            chk(s == SW'(k), "R9 slot order", 128'(s), 128'(k));
        end
        chk(!sched_valid, "R5 nothing extra", 128'(sched_valid), 0);

        // Free slot 2 (queue 2) and reuse it
        done1(2'd2);
        push1(2, mk(2, 9), acc);
        take(d, s);
        chk(d == mk(2, 9), "R4 released queue proceeds", 128'(d), 128'(mk(2, 9)));
        chk(s == 2'd2, "R9 freed slot reused", 128'(s), 2);
        done1(2'd0);
        done1(2'd1);
        done1(2'd3);
        done1(2'd2);

        // Pointer now after queue 2: queues 0,1,3 together -> 3,0,1
        push_desc[0*DESC_W +: DESC_W] = mk(0, 10);
        push_desc[1*DESC_W +: DESC_W] = mk(1, 10);
        push_desc[3*DESC_W +: DESC_W] = mk(3, 10);
        push_valid = 4'b1011;
        @(negedge clk);
        push_valid = '0;
        for (int k = 0; k < 3; k++) begin
            int eq;
            eq = (k == 0) ? 3 : k - 1;
            take(d, s);
            // R6, R7: one per cycle, rotating from queue 3
            chk(d == mk(eq, 10), "R6 rr resume", 128'(d), 128'(mk(eq, 10)));
            chk(s == SW'(k), "R9 slot alloc", 128'(s), 128'(k));
            done1(s);
        end
        repeat (4) @(negedge clk);
        chk(!sched_valid, "R10 idle at end", 128'(sched_valid), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule